// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller for a pipeline whose functional units may finish out of order. Every accepted instruction goes through four phases: issue, operand read, execute and result write. The controller keeps a status record for each functional unit and a table that says which unit, if any, will write each architectural register. With these it decides, cycle by cycle, which units may read their operands and which may write their results. The block carries no operand values and does no register renaming.

The front end presents one instruction at a time: an opcode class, a destination and two source registers. The class selects the single functional unit that runs it. The instruction is taken only when the unit is free and no in-flight instruction already targets the same destination. A refused instruction blocks everything behind it, so issue stays in program order. For each unit the controller raises a one-cycle operand-read enable once neither source has a pending producer. The unit then reports the end of execution on its done input. The controller grants the register write only when no older instruction still has to read the register's old value.

Top module: `sb_ctrl`

## Requirements
- R1: After reset every unit is idle: `issue_ready` is 1, and `fu_start`, `fu_wb` and `rf_wr_en` are all 0.
- R2: `issue_ready` is 0 while the unit selected by `issue_cls` (class value k selects unit k) holds an instruction. No issue occurs while `issue_ready` is 0.
- R3: `issue_ready` is 0 while any in-flight instruction has `issue_dst` as its destination. It returns to 1 in the cycle after that instruction's write grant.
- R4: A unit whose source register has a pending producer does not assert its `fu_start` bit until the cycle after that producer's `fu_wb` bit.
- R5: A unit whose sources have no pending producer asserts its `fu_start` bit in the cycle after issue. Each `fu_start` pulse lasts exactly one cycle per instruction.
- R6: A `fu_done` bit seen while that unit is executing leads to the unit's write request in the next cycle. The grant comes in that cycle if no other constraint holds it.
- R7: A unit's `fu_wb` bit stays 0 while another unit still has to read the old value of the destination register: the register is a source of that unit, and the operand is ready but not yet read.
- R8: At most one `fu_wb` bit is 1 in a cycle, and the lowest-numbered requesting unit wins. `rf_wr_en` is 1 in that cycle, with `rf_wr_addr` equal to the winner's destination register.
- R9: A unit is free again, and its destination register has no pending producer, from the cycle after its `fu_wb` bit.
- R10: A `fu_done` bit is ignored while its unit is idle or still waiting to read operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented for issue |
| issue_cls | input | FU_W | Opcode class; value k selects unit k |
| issue_dst | input | REG_W | Destination register |
| issue_src1 | input | REG_W | First source register |
| issue_src2 | input | REG_W | Second source register |
| issue_ready | output | 1 | Presented instruction can be accepted this cycle |
| fu_done | input | NUM_FU | Per-unit end of execution |
| fu_start | output | NUM_FU | Per-unit operand-read enable, starts execution |
| fu_wb | output | NUM_FU | Per-unit result write grant |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | REG_W | Register file write address |

## Verification
On every cycle the assertions check the following. An accepted issue always occupies its unit and marks its destination as pending. At most one write grant exists per cycle, and it matches the register write enable. No unit is granted while a pending read blocks it. Each start pulse lasts one cycle, and a granted unit is free afterwards. Only the directed scenarios can show the ordering across instructions: a consumer starting exactly one cycle after its producer writes, a second writer to the same register waiting for the first to retire, a write held back until an older reader has its old value, and early done pulses having no effect. The scenarios also show when issue reopens and which unit wins when two request the write together.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

endpackage

// File: rtl/sb_unit_status.sv
module sb_unit_status #(
  parameter int REG_W = 3,
  parameter int FU_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  input  logic             in_q1_vld,
  input  logic [FU_W-1:0]  in_q1_id,
  input  logic             in_q2_vld,
  input  logic [FU_W-1:0]  in_q2_id,
  input  logic             bc_vld,
  input  logic [FU_W-1:0]  bc_id,
  input  logic             done_in,
  input  logic             wb_grant,
  output logic             busy_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             rj_o,
  output logic             rk_o,
  output logic             start_o,
  output logic             wb_req_o
);
  import sb_pkg::*;

  phase_e           phase_q;
  logic [REG_W-1:0] fi_q, fj_q, fk_q;
  logic             qj_vld_q, qk_vld_q;
  logic [FU_W-1:0]  qj_q, qk_q;
  logic             rj_q, rk_q;

  logic hit_j, hit_k;
  assign hit_j = qj_vld_q && bc_vld && (qj_q == bc_id);
  assign hit_k = qk_vld_q && bc_vld && (qk_q == bc_id);

  assign busy_o   = (phase_q != PH_IDLE);
  assign start_o  = (phase_q == PH_READ) && rj_q && rk_q;
  assign wb_req_o = (phase_q == PH_WRITE);
  assign fi_o     = fi_q;
  assign fj_o     = fj_q;
  assign fk_o     = fk_q;
  assign rj_o     = rj_q;
  assign rk_o     = rk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      fi_q     <= '0;
      fj_q     <= '0;
      fk_q     <= '0;
      qj_vld_q <= 1'b0;
      qk_vld_q <= 1'b0;
      qj_q     <= '0;
      qk_q     <= '0;
      rj_q     <= 1'b0;
      rk_q     <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (issue_en) begin
            phase_q  <= PH_READ;
            fi_q     <= in_dst;
            fj_q     <= in_src1;
            fk_q     <= in_src2;
            qj_vld_q <= in_q1_vld;
            qk_vld_q <= in_q2_vld;
            qj_q     <= in_q1_id;
            qk_q     <= in_q2_id;
            rj_q     <= !in_q1_vld;
            rk_q     <= !in_q2_vld;
          end
        end
        PH_READ: begin
          if (start_o) begin
            phase_q <= PH_EXEC;
            rj_q    <= 1'b0;
            rk_q    <= 1'b0;
          end else begin
            if (hit_j) begin
              qj_vld_q <= 1'b0;
              rj_q     <= 1'b1;
            end
            if (hit_k) begin
              qk_vld_q <= 1'b0;
              rk_q     <= 1'b1;
            end
          end
        end
        PH_EXEC: begin
          if (done_in) phase_q <= PH_WRITE;
        end
        PH_WRITE: begin
          if (wb_grant) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REG = 8,
  parameter int FU_W    = 2,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [REG_W-1:0]               set_reg,
  input  logic [FU_W-1:0]                set_id,
  input  logic                           clr_en,
  input  logic [REG_W-1:0]               clr_reg,
  output logic [NUM_REG-1:0]             prod_vld,
  output logic [NUM_REG-1:0][FU_W-1:0]   prod_id
);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_vld[r] <= 1'b0;
        prod_id[r]  <= '0;
      end else if (set_en && (set_reg == REG_W'(r))) begin
        prod_vld[r] <= 1'b1;
        prod_id[r]  <= set_id;
      end else if (clr_en && (clr_reg == REG_W'(r))) begin
        prod_vld[r] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [FU_W-1:0]   issue_cls,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [REG_W-1:0]  issue_src1,
  input  logic [REG_W-1:0]  issue_src2,
  output logic              issue_ready,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] fu_start,
  output logic [NUM_FU-1:0] fu_wb,
  output logic              rf_wr_en,
  output logic [REG_W-1:0]  rf_wr_addr
);

  // Index of the single set bit of a grant vector.
  function automatic logic [FU_W-1:0] onehot_index(input logic [NUM_FU-1:0] v);
    logic [FU_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (v[i]) idx = FU_W'(i);
    end
    return idx;
  endfunction

  // True when unit 'self' must hold its write: another unit has the
  // destination register as a ready, not yet read, source.
  function automatic logic read_pending(
    input int                            self,
    input logic [REG_W-1:0]              reg_w,
    input logic [NUM_FU-1:0]             bsy,
    input logic [NUM_FU-1:0][REG_W-1:0]  fj,
    input logic [NUM_FU-1:0][REG_W-1:0]  fk,
    input logic [NUM_FU-1:0]             rj,
    input logic [NUM_FU-1:0]             rk
  );
    logic hold;
    hold = 1'b0;
    for (int v = 0; v < NUM_FU; v++) begin
      if (v != self && bsy[v] &&
          ((rj[v] && fj[v] == reg_w) || (rk[v] && fk[v] == reg_w)))
        hold = 1'b1;
    end
    return hold;
  endfunction

  logic [NUM_FU-1:0]                busy;
  logic [NUM_FU-1:0][REG_W-1:0]     fi, fj, fk;
  logic [NUM_FU-1:0]                rj, rk;
  logic [NUM_FU-1:0]                wb_req;
  logic [NUM_FU-1:0]                war_block;
  logic [NUM_FU-1:0]                wb_elig;
  logic [NUM_REG-1:0]               prod_vld;
  logic [NUM_REG-1:0][FU_W-1:0]     prod_id;

  logic             cls_ok;
  logic             unit_free;
  logic             waw_hit;
  logic             issue_fire;
  logic             bc_vld;
  logic [FU_W-1:0]  bc_id;
  logic             q1_vld, q2_vld;

  // Issue checks: structural and write-after-write.
  assign cls_ok      = (int'(issue_cls) < NUM_FU);
  assign unit_free   = cls_ok && !busy[issue_cls];
  assign waw_hit     = prod_vld[issue_dst];
  assign issue_ready = unit_free && !waw_hit;
  assign issue_fire  = issue_valid && issue_ready;

  // Result broadcast of this cycle.
  assign bc_vld = |fu_wb;
  assign bc_id  = onehot_index(fu_wb);

  // A producer writing in the issue cycle counts as already written.
  assign q1_vld = prod_vld[issue_src1] && !(bc_vld && prod_id[issue_src1] == bc_id);
  assign q2_vld = prod_vld[issue_src2] && !(bc_vld && prod_id[issue_src2] == bc_id);

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    sb_unit_status #(
      .REG_W(REG_W),
      .FU_W (FU_W)
    ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_en (issue_fire && (issue_cls == FU_W'(u))),
      .in_dst   (issue_dst),
      .in_src1  (issue_src1),
      .in_src2  (issue_src2),
      .in_q1_vld(q1_vld),
      .in_q1_id (prod_id[issue_src1]),
      .in_q2_vld(q2_vld),
      .in_q2_id (prod_id[issue_src2]),
      .bc_vld   (bc_vld),
      .bc_id    (bc_id),
      .done_in  (fu_done[u]),
      .wb_grant (fu_wb[u]),
      .busy_o   (busy[u]),
      .fi_o     (fi[u]),
      .fj_o     (fj[u]),
      .fk_o     (fk[u]),
      .rj_o     (rj[u]),
      .rk_o     (rk[u]),
      .start_o  (fu_start[u]),
      .wb_req_o (wb_req[u])
    );

    assign war_block[u] = read_pending(u, fi[u], busy, fj, fk, rj, rk);
    assign wb_elig[u]   = wb_req[u] && !war_block[u];
  end

  sb_wb_arbiter #(
    .N(NUM_FU)
  ) u_arb (
    .req(wb_elig),
    .gnt(fu_wb)
  );

  sb_reg_status #(
    .NUM_REG(NUM_REG),
    .FU_W   (FU_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (issue_dst),
    .set_id  (issue_cls),
    .clr_en  (bc_vld),
    .clr_reg (rf_wr_addr),
    .prod_vld(prod_vld),
    .prod_id (prod_id)
  );

  assign rf_wr_en   = bc_vld;
  assign rf_wr_addr = fi[bc_id];

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_fire,
  input logic [FU_W-1:0]   issue_cls,
  input logic [REG_W-1:0]  issue_dst,
  input logic [NUM_FU-1:0] busy,
  input logic [NUM_REG-1:0] prod_vld,
  input logic [NUM_FU-1:0] war_block,
  input logic [NUM_FU-1:0] fu_start,
  input logic [NUM_FU-1:0] fu_wb,
  input logic              rf_wr_en
);

  p_issue_takes_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> busy[$past(issue_cls)]);

  p_dst_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> prod_vld[$past(issue_dst)]);

  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fu_wb));

  p_write_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en == (fu_wb != '0));

  for (genvar u = 0; u < NUM_FU; u++) begin : g_u
    p_war_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fu_wb[u] |-> !war_block[u]);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fu_start[u] |=> !fu_start[u]);

    p_free_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fu_wb[u] |=> !busy[u]);
  end

endmodule

bind sb_ctrl sb_chk #(
  .NUM_FU (NUM_FU),
  .NUM_REG(NUM_REG)
) u_sb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_fire(issue_fire),
  .issue_cls (issue_cls),
  .issue_dst (issue_dst),
  .busy      (busy),
  .prod_vld  (prod_vld),
  .war_block (war_block),
  .fu_start  (fu_start),
  .fu_wb     (fu_wb),
  .rf_wr_en  (rf_wr_en)
);

// File: tb/tb_sb_ctrl.sv
module tb_sb_ctrl;

  localparam int NUM_FU  = 4;
  localparam int NUM_REG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_valid = 1'b0;
  logic [1:0] issue_cls = '0;
  logic [2:0] issue_dst = '0;
  logic [2:0] issue_src1 = '0;
  logic [2:0] issue_src2 = '0;
  logic       issue_ready;
  logic [3:0] fu_done = '0;
  logic [3:0] fu_start;
  logic [3:0] fu_wb;
  logic       rf_wr_en;
  logic [2:0] rf_wr_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  sb_ctrl #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_cls  (issue_cls),
    .issue_dst  (issue_dst),
    .issue_src1 (issue_src1),
    .issue_src2 (issue_src2),
    .issue_ready(issue_ready),
    .fu_done    (fu_done),
    .fu_start   (fu_start),
    .fu_wb      (fu_wb),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic put(input int c, input int d, input int s1, input int s2);
    issue_valid = 1'b1;
    issue_cls   = 2'(c);
    issue_dst   = 3'(d);
    issue_src1  = 3'(s1);
    issue_src2  = 3'(s2);
  endtask

  task automatic drop();
    issue_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drop();
    fu_done = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    settle();
    chk("R1 issue_ready", int'(issue_ready), 1);
    chk("R1 fu_start", int'(fu_start), 0);
    chk("R1 fu_wb", int'(fu_wb), 0);
    chk("R1 rf_wr_en", int'(rf_wr_en), 0);
  endtask

  // RAW chain: unit1 reads r3 produced by unit0.
  task automatic t_raw();
    step();
    put(0, 3, 1, 2);
    settle();
    chk("R2 ready on free unit", int'(issue_ready), 1);
    step();
    put(1, 4, 3, 5);
    settle();
    chk("R5 start unit0", int'(fu_start), 4'b0001);
    step();
    drop();
    fu_done = 4'b0001;
    settle();
    chk("R4 consumer waits", int'(fu_start), 4'b0000);
    step();
    fu_done = '0;
    settle();
    chk("R6 write unit0", int'(fu_wb), 4'b0001);
    chk("R8 wr addr r3", int'(rf_wr_addr), 3);
    chk("R4 no start same cycle", int'(fu_start), 4'b0000);
    step();
    settle();
    chk("R4 consumer starts", int'(fu_start), 4'b0010);
    step();
    fu_done = 4'b0010;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R6 write unit1", int'(fu_wb), 4'b0010);
    chk("R8 wr addr r4", int'(rf_wr_addr), 4);
    step();
    settle();
    chk("R9 idle after chain", int'(fu_wb), 0);
  endtask

  // WAW pair on r5, with an early done pulse.
  task automatic t_waw();
    step();
    put(0, 5, 1, 2);
    settle();
    step();
    put(1, 5, 3, 4);
    fu_done = 4'b0001;
    settle();
    chk("R3 WAW blocks issue", int'(issue_ready), 0);
    chk("R5 start unit0", int'(fu_start), 4'b0001);
    step();
    settle();
    chk("R10 early done ignored", int'(fu_wb), 0);
    chk("R3 still blocked", int'(issue_ready), 0);
    step();
    fu_done = '0;
    settle();
    chk("R6 first writer", int'(fu_wb), 4'b0001);
    chk("R3 blocked during write", int'(issue_ready), 0);
    step();
    settle();
    chk("R3 issue reopens", int'(issue_ready), 1);
    step();
    drop();
    settle();
    chk("R5 second writer starts", int'(fu_start), 4'b0010);
    step();
    fu_done = 4'b0010;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R8 second write r5", int'(rf_wr_addr), 5);
    chk("R6 second writer wb", int'(fu_wb), 4'b0010);
    step();
  endtask

  // WAR pair: unit1 must read old r4 before unit2 writes r4.
  task automatic t_war();
    step();
    put(0, 2, 0, 0);
    settle();
    step();
    put(1, 3, 2, 4);
    settle();
    chk("R5 start unit0", int'(fu_start), 4'b0001);
    step();
    put(2, 4, 0, 0);
    settle();
    chk("R2 unit2 free", int'(issue_ready), 1);
    step();
    drop();
    settle();
    chk("R5 start unit2 only", int'(fu_start), 4'b0100);
    step();
    fu_done = 4'b0100;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R7 write held", int'(fu_wb), 0);
    step();
    settle();
    chk("R7 write still held", int'(fu_wb), 0);
    fu_done = 4'b0001;
    step();
    fu_done = '0;
    settle();
    chk("R7 producer writes r2", int'(fu_wb), 4'b0001);
    chk("R8 wr addr r2", int'(rf_wr_addr), 2);
    step();
    settle();
    chk("R4 reader starts", int'(fu_start), 4'b0010);
    chk("R7 held while reading", int'(fu_wb), 0);
    step();
    settle();
    chk("R7 released after read", int'(fu_wb), 4'b0100);
    chk("R8 wr addr r4", int'(rf_wr_addr), 4);
    step();
    fu_done = 4'b0010;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R6 reader writes r3", int'(fu_wb), 4'b0010);
    step();
  endtask

  // Two units request the write together.
  task automatic t_prio();
    step();
    put(0, 1, 0, 0);
    settle();
    step();
    put(1, 2, 0, 0);
    settle();
    chk("R5 start unit0", int'(fu_start), 4'b0001);
    step();
    put(0, 5, 0, 0);
    settle();
    chk("R2 busy unit blocks", int'(issue_ready), 0);
    chk("R5 start unit1", int'(fu_start), 4'b0010);
    step();
    drop();
    fu_done = 4'b0011;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R8 lowest wins", int'(fu_wb), 4'b0001);
    chk("R8 addr r1", int'(rf_wr_addr), 1);
    step();
    put(0, 5, 0, 0);
    settle();
    chk("R8 next writer", int'(fu_wb), 4'b0010);
    chk("R8 addr r2", int'(rf_wr_addr), 2);
    chk("R9 unit0 free", int'(issue_ready), 1);
    step();
    drop();
    settle();
    chk("R9 reissue starts", int'(fu_start), 4'b0001);
    step();
    fu_done = 4'b0001;
    settle();
    step();
    fu_done = '0;
    settle();
    chk("R8 addr r5", int'(rf_wr_addr), 5);
    step();
  endtask

  initial begin
    t_reset();
    t_raw();
    t_waw();
    t_war();
    t_prio();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule